// File: doc/BRIEF.md
# Operand-Tag Wakeup Issue Window

This block holds instructions that have been renamed but not yet issued. Every source operand slot holds one of two kinds of tag. While it waits, the slot holds the number of the virtual-physical register that names the producing result. Once that result exists, the slot holds the number of the physical register where the value lives. A per-operand ready flag says which kind of tag is present.

Results are announced on a single writeback broadcast port. Each announcement pairs a virtual-physical number with the physical register just bound to it. A waiting operand whose tag matches takes the announced physical number in place of its own tag and turns ready.

Once both operands of an entry are ready, the entry may leave the window. It leaves carrying its two physical source numbers, for the register file read, and its destination virtual-physical number. At most one entry issues per cycle, and it is always the oldest eligible one. A full window raises a stall toward dispatch. A flush empties the window.

Top module: `owk_wake_window`

## Requirements
- R1: While reset is held and in the first cycle after it, `iss_valid` and `stall` are 0.
- R2: An entry dispatched with both ready flags at 1 presents `iss_valid`=1 in the cycle after dispatch. In that cycle `iss_src0_pr`/`iss_src1_pr` equal the low PTAG_W bits of its dispatched tags and `iss_dst_vpr` equals its dispatched destination; the entry then leaves the window.
- R3: A waiting operand (ready flag 0) whose VTAG_W-bit tag equals `bc_vpr` while `bc_valid`=1 becomes ready. Its field is replaced by `bc_pr`, so an entry whose other operand is ready issues one cycle after the broadcast with that operand equal to `bc_pr`.
- R4: An operand dispatched with ready flag 1 never compares against the broadcast: a broadcast whose `bc_vpr` equals its tag leaves its physical number unchanged.
- R5: A broadcast whose `bc_vpr` differs from a waiting operand's tag leaves the operand waiting, and the entry does not issue.
- R6: A broadcast in the same cycle as the dispatch of an entry with a matching waiting operand is captured. The entry issues in the next cycle with that operand equal to `bc_pr`.
- R7: When several entries are eligible, only the one dispatched earliest issues in a cycle, independent of which slot it occupies.
- R8: `stall` is 1 exactly when all DEPTH entries are occupied. A dispatch presented while `stall`=1 is discarded.
- R9: `flush`=1 invalidates every entry by the next cycle and drops any dispatch in the same cycle. `iss_valid` is 0 while `flush` is 1.
- R10: With `bc_valid`=0, no operand wakes, whatever the value of `bc_vpr`.
- R11: Both operands of one entry waiting on the same tag wake on the same broadcast and both take `bc_pr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| disp_valid | input | 1 | Dispatch request |
| disp_s0_rdy | input | 1 | Source 0 ready flag (1: tag is physical) |
| disp_s0_tag | input | TAG_W | Source 0 tag (physical in low PTAG_W bits when ready) |
| disp_s1_rdy | input | 1 | Source 1 ready flag |
| disp_s1_tag | input | TAG_W | Source 1 tag |
| disp_dst_vpr | input | VTAG_W | Destination virtual-physical number |
| bc_valid | input | 1 | Writeback broadcast valid |
| bc_vpr | input | VTAG_W | Broadcast virtual-physical number |
| bc_pr | input | PTAG_W | Physical register bound to `bc_vpr` |
| stall | output | 1 | Window full |
| iss_valid | output | 1 | An entry issues this cycle |
| iss_src0_pr | output | PTAG_W | Physical number of source 0 |
| iss_src1_pr | output | PTAG_W | Physical number of source 1 |
| iss_dst_vpr | output | VTAG_W | Destination virtual-physical number of the issuing entry |

## Verification
The properties take three things for granted. Only one broadcast arrives per cycle. A dispatch is presented only with fully formed tags. An entry that issues leaves on the next edge with no acknowledgement. The dispatch-outcome properties are also limited to dispatches into an empty window, because only there is the issuing entry known without a model.

The stimulus keeps within these assumptions. It flushes or drains the window between sweep vectors, so each vector starts empty. It sends at most one dispatch and one broadcast per cycle. In the sweeps, every tag a vector waits on is announced at most once.

// File: rtl/owk_pkg.sv
package owk_pkg;
  localparam int OWK_VTAG_W = 5;
  localparam int OWK_PTAG_W = 4;
  localparam int OWK_DEPTH  = 4;

  typedef enum logic {
    OP_WAIT  = 1'b0,
    OP_READY = 1'b1
  } op_state_e;

  function automatic int tag_width(input int vw, input int pw);
    return (vw > pw) ? vw : pw;
  endfunction
endpackage

// File: rtl/owk_operand.sv
module owk_operand
  import owk_pkg::*;
#(
  parameter int VW = OWK_VTAG_W,
  parameter int PW = OWK_PTAG_W,
  parameter int TW = tag_width(OWK_VTAG_W, OWK_PTAG_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          ld_rdy,
  input  logic [TW-1:0] ld_tag,
  input  logic          bc_valid,
  input  logic [VW-1:0] bc_vpr,
  input  logic [PW-1:0] bc_pr,
  output logic          rdy,
  output logic [PW-1:0] pr
);
  op_state_e     state_q, state_d;
  logic [TW-1:0] tag_q, tag_d;
  logic          en;
  logic          hit_ld, hit_q;

  assign hit_ld = bc_valid && !ld_rdy && (ld_tag[VW-1:0] == bc_vpr);
  assign hit_q  = bc_valid && (state_q == OP_WAIT) && (tag_q[VW-1:0] == bc_vpr);

  always_comb begin
    state_d = state_q;
    tag_d   = tag_q;
    en      = 1'b0;
    if (load) begin
      en = 1'b1;
      if (hit_ld) begin
        state_d = OP_READY;
        tag_d   = TW'(bc_pr);
      end else begin
        state_d = ld_rdy ? OP_READY : OP_WAIT;
        tag_d   = ld_tag;
      end
    end else if (hit_q) begin
      en      = 1'b1;
      state_d = OP_READY;
      tag_d   = TW'(bc_pr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= OP_WAIT;
      tag_q   <= '0;
    end else if (en) begin
      state_q <= state_d;
      tag_q   <= tag_d;
    end
  end

  assign rdy = (state_q == OP_READY);
  assign pr  = tag_q[PW-1:0];
endmodule

// File: rtl/owk_entry.sv
module owk_entry
  import owk_pkg::*;
#(
  parameter int VW = OWK_VTAG_W,
  parameter int PW = OWK_PTAG_W,
  parameter int TW = tag_width(OWK_VTAG_W, OWK_PTAG_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          issue,
  input  logic          flush,
  input  logic          ld_s0_rdy,
  input  logic [TW-1:0] ld_s0_tag,
  input  logic          ld_s1_rdy,
  input  logic [TW-1:0] ld_s1_tag,
  input  logic [VW-1:0] ld_dst,
  input  logic          bc_valid,
  input  logic [VW-1:0] bc_vpr,
  input  logic [PW-1:0] bc_pr,
  output logic          valid,
  output logic          both_rdy,
  output logic [PW-1:0] src0_pr,
  output logic [PW-1:0] src1_pr,
  output logic [VW-1:0] dst
);
  logic          valid_q, valid_d;
  logic [VW-1:0] dst_q;
  logic          r0, r1;

  always_comb begin
    valid_d = valid_q;
    if (flush)      valid_d = 1'b0;
    else if (load)  valid_d = 1'b1;
    else if (issue) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      dst_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (load) dst_q <= ld_dst;
    end
  end

  owk_operand #(.VW(VW), .PW(PW), .TW(TW)) u_op0 (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_rdy(ld_s0_rdy), .ld_tag(ld_s0_tag),
    .bc_valid(bc_valid), .bc_vpr(bc_vpr), .bc_pr(bc_pr), .rdy(r0), .pr(src0_pr)
  );

  owk_operand #(.VW(VW), .PW(PW), .TW(TW)) u_op1 (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_rdy(ld_s1_rdy), .ld_tag(ld_s1_tag),
    .bc_valid(bc_valid), .bc_vpr(bc_vpr), .bc_pr(bc_pr), .rdy(r1), .pr(src1_pr)
  );

  assign valid    = valid_q;
  assign both_rdy = r0 && r1;
  assign dst      = dst_q;
endmodule

// File: rtl/owk_age_pick.sv
module owk_age_pick #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  // older_q[i][j] = 1 : slot i was written before slot j
  logic [N-1:0] older_q [N];
  logic [N-1:0] older_d [N];
  logic         en;

  assign en = |alloc;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        older_d[i][j] = older_q[i][j];
        if (alloc[i]) older_d[i][j] = 1'b0;
        if (alloc[j] && (i != j)) older_d[i][j] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) older_q[i] <= '0;
    end else if (en) begin
      for (int i = 0; i < N; i++) older_q[i] <= older_d[i];
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < N; j++) begin
        if ((j != i) && req[j] && older_q[j][i]) blocked = 1'b1;
      end
      grant[i] = req[i] && !blocked;
    end
  end
endmodule

// File: rtl/owk_wake_window.sv
module owk_wake_window
  import owk_pkg::*;
#(
  parameter int DEPTH  = OWK_DEPTH,
  parameter int VTAG_W = OWK_VTAG_W,
  parameter int PTAG_W = OWK_PTAG_W,
  parameter int TAG_W  = tag_width(OWK_VTAG_W, OWK_PTAG_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              disp_valid,
  input  logic              disp_s0_rdy,
  input  logic [TAG_W-1:0]  disp_s0_tag,
  input  logic              disp_s1_rdy,
  input  logic [TAG_W-1:0]  disp_s1_tag,
  input  logic [VTAG_W-1:0] disp_dst_vpr,
  input  logic              bc_valid,
  input  logic [VTAG_W-1:0] bc_vpr,
  input  logic [PTAG_W-1:0] bc_pr,
  output logic              stall,
  output logic              iss_valid,
  output logic [PTAG_W-1:0] iss_src0_pr,
  output logic [PTAG_W-1:0] iss_src1_pr,
  output logic [VTAG_W-1:0] iss_dst_vpr
);
  logic [DEPTH-1:0]  ent_valid;
  logic [DEPTH-1:0]  ent_rdy;
  logic [DEPTH-1:0]  free_oh;
  logic [DEPTH-1:0]  alloc;
  logic [DEPTH-1:0]  req;
  logic [DEPTH-1:0]  grant;
  logic [PTAG_W-1:0] e_src0 [DEPTH];
  logic [PTAG_W-1:0] e_src1 [DEPTH];
  logic [VTAG_W-1:0] e_dst  [DEPTH];
  logic              full;

  assign full = &ent_valid;

  always_comb begin
    logic found;
    found   = 1'b0;
    free_oh = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!ent_valid[i] && !found) begin
        free_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign alloc = (disp_valid && !flush && !full) ? free_oh : '0;
  assign req   = flush ? '0 : (ent_valid & ent_rdy);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    owk_entry #(.VW(VTAG_W), .PW(PTAG_W), .TW(TAG_W)) u_ent (
      .clk(clk), .rst_n(rst_n), .load(alloc[g]), .issue(grant[g]), .flush(flush),
      .ld_s0_rdy(disp_s0_rdy), .ld_s0_tag(disp_s0_tag),
      .ld_s1_rdy(disp_s1_rdy), .ld_s1_tag(disp_s1_tag), .ld_dst(disp_dst_vpr),
      .bc_valid(bc_valid), .bc_vpr(bc_vpr), .bc_pr(bc_pr),
      .valid(ent_valid[g]), .both_rdy(ent_rdy[g]),
      .src0_pr(e_src0[g]), .src1_pr(e_src1[g]), .dst(e_dst[g])
    );
  end

  owk_age_pick #(.N(DEPTH)) u_pick (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .req(req), .grant(grant)
  );

  always_comb begin
    iss_src0_pr = '0;
    iss_src1_pr = '0;
    iss_dst_vpr = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (grant[i]) begin
        iss_src0_pr = iss_src0_pr | e_src0[i];
        iss_src1_pr = iss_src1_pr | e_src1[i];
        iss_dst_vpr = iss_dst_vpr | e_dst[i];
      end
    end
  end

  assign iss_valid = |grant;
  assign stall     = full;
endmodule

// File: rtl/owk_wake_window_chk.sv
module owk_wake_window_chk #(
  parameter int N  = 4,
  parameter int VW = 5,
  parameter int PW = 4,
  parameter int TW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          disp_valid,
  input logic          disp_s0_rdy,
  input logic [TW-1:0] disp_s0_tag,
  input logic          disp_s1_rdy,
  input logic [VW-1:0] disp_dst_vpr,
  input logic          bc_valid,
  input logic [VW-1:0] bc_vpr,
  input logic [PW-1:0] bc_pr,
  input logic          stall,
  input logic          iss_valid,
  input logic [PW-1:0] iss_src0_pr,
  input logic [VW-1:0] iss_dst_vpr,
  input logic [N-1:0]  ent_valid,
  input logic [N-1:0]  grant
);
  AST_READY_DISPATCH_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !flush && ent_valid == '0 && disp_s0_rdy && disp_s1_rdy) |=>
    (flush || (iss_valid && iss_dst_vpr == $past(disp_dst_vpr) &&
               iss_src0_pr == $past(disp_s0_tag[PW-1:0])))); // R2

  AST_SAME_CYCLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !flush && ent_valid == '0 && !disp_s0_rdy && disp_s1_rdy &&
     bc_valid && disp_s0_tag[VW-1:0] == bc_vpr) |=>
    (flush || (iss_valid && iss_src0_pr == $past(bc_pr)))); // R6

  AST_WAITING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !flush && ent_valid == '0 && !disp_s0_rdy && !bc_valid) |=>
    !iss_valid); // R10

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R7

  AST_FULL_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !iss_valid && !flush) |=> stall); // R8

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!iss_valid && !stall)); // R9
endmodule

bind owk_wake_window owk_wake_window_chk #(
  .N(DEPTH), .VW(VTAG_W), .PW(PTAG_W), .TW(TAG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .disp_valid(disp_valid),
  .disp_s0_rdy(disp_s0_rdy), .disp_s0_tag(disp_s0_tag), .disp_s1_rdy(disp_s1_rdy),
  .disp_dst_vpr(disp_dst_vpr), .bc_valid(bc_valid), .bc_vpr(bc_vpr), .bc_pr(bc_pr),
  .stall(stall), .iss_valid(iss_valid), .iss_src0_pr(iss_src0_pr),
  .iss_dst_vpr(iss_dst_vpr), .ent_valid(ent_valid), .grant(grant)
);

// File: tb/sim_owk_wake_window.sv
module sim_owk_wake_window;
  localparam int VW = 5;
  localparam int PW = 4;
  localparam int TW = 5;

  logic          clk;
  logic          rst_n;
  logic          flush;
  logic          disp_valid;
  logic          disp_s0_rdy;
  logic [TW-1:0] disp_s0_tag;
  logic          disp_s1_rdy;
  logic [TW-1:0] disp_s1_tag;
  logic [VW-1:0] disp_dst_vpr;
  logic          bc_valid;
  logic [VW-1:0] bc_vpr;
  logic [PW-1:0] bc_pr;
  logic          stall;
  logic          iss_valid;
  logic [PW-1:0] iss_src0_pr;
  logic [PW-1:0] iss_src1_pr;
  logic [VW-1:0] iss_dst_vpr;

  int nchk  = 0;
  int nfail = 0;
  int ncyc  = 0;

  owk_wake_window #(.DEPTH(4), .VTAG_W(VW), .PTAG_W(PW), .TAG_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .disp_valid(disp_valid),
    .disp_s0_rdy(disp_s0_rdy), .disp_s0_tag(disp_s0_tag),
    .disp_s1_rdy(disp_s1_rdy), .disp_s1_tag(disp_s1_tag), .disp_dst_vpr(disp_dst_vpr),
    .bc_valid(bc_valid), .bc_vpr(bc_vpr), .bc_pr(bc_pr),
    .stall(stall), .iss_valid(iss_valid), .iss_src0_pr(iss_src0_pr),
    .iss_src1_pr(iss_src1_pr), .iss_dst_vpr(iss_dst_vpr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    ncyc <= ncyc + 1;
    if (ncyc > 100000) begin
      nchk  = nchk + 1;
      nfail = nfail + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", ncyc);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nchk = nchk + 1;
    if (act != exp) begin
      nfail = nfail + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    flush = 0; disp_valid = 0; disp_s0_rdy = 0; disp_s0_tag = '0;
    disp_s1_rdy = 0; disp_s1_tag = '0; disp_dst_vpr = '0;
    bc_valid = 0; bc_vpr = '0; bc_pr = '0;
  endtask

  task automatic dispatch(input bit r0, input int t0, input bit r1, input int t1, input int d);
    disp_valid = 1; disp_s0_rdy = r0; disp_s0_tag = TW'(t0);
    disp_s1_rdy = r1; disp_s1_tag = TW'(t1); disp_dst_vpr = VW'(d);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    tick();
    check("R1 iss_valid in reset", int'(iss_valid), 0);
    check("R1 stall in reset", int'(stall), 0);
    tick();
    rst_n = 1;
    tick();
    check("R1 iss_valid after reset", int'(iss_valid), 0);
    check("R1 stall after reset", int'(stall), 0);

    // Sweep: wake after dispatch, every waiting tag against every broadcast tag
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        int p1, bp, d;
        p1 = (a + 3) % 16; bp = (b * 7 + 1) % 16; d = (a + b) % 32;
        dispatch(0, a, 1, p1, d);
        bc_valid = 0; bc_vpr = VW'(a); bc_pr = PW'(bp);
        tick();
        disp_valid = 0;
        check("R10 no wake without bc_valid", int'(iss_valid), 0);
        bc_valid = 1; bc_vpr = VW'(b); bc_pr = PW'(bp);
        tick();
        bc_valid = 0;
        if (a == b) begin
          check("R3 wake issues", int'(iss_valid), 1);
          check("R3 src0 replaced", int'(iss_src0_pr), bp);
          check("R2 src1 physical", int'(iss_src1_pr), p1);
          check("R2 dst tag", int'(iss_dst_vpr), d);
        end else begin
          check("R5 mismatch no issue", int'(iss_valid), 0);
          flush = 1;
        end
        tick();
        flush = 0;
        check("R9 window empty iss", int'(iss_valid), 0);
        check("R9 window empty stall", int'(stall), 0);
      end
    end

    // Sweep: broadcast in the dispatch cycle
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        int bp;
        bp = (a * 5 + b) % 16;
        dispatch(0, a, 1, 2, b);
        bc_valid = 1; bc_vpr = VW'(b); bc_pr = PW'(bp);
        tick();
        disp_valid = 0; bc_valid = 0;
        if (a == b) begin
          check("R6 same-cycle capture", int'(iss_valid), 1);
          check("R6 src0 from broadcast", int'(iss_src0_pr), bp);
        end else begin
          check("R5 same-cycle mismatch", int'(iss_valid), 0);
          flush = 1;
        end
        tick();
        flush = 0;
        check("R9 cleared after vector", int'(iss_valid), 0);
      end
    end

    // Ready operands at dispatch, sweep of physical numbers
    for (int p = 0; p < 16; p++) begin
      dispatch(1, p, 1, 15 - p, p + 16);
      bc_valid = 1; bc_vpr = VW'(p); bc_pr = PW'(p ^ 5);
      tick();
      disp_valid = 0; bc_valid = 0;
      check("R2 ready dispatch issues", int'(iss_valid), 1);
      check("R4 ready src0 not replaced", int'(iss_src0_pr), p);
      check("R2 src1", int'(iss_src1_pr), 15 - p);
      check("R2 dst", int'(iss_dst_vpr), p + 16);
      tick();
      check("R2 entry left", int'(iss_valid), 0);
    end

    // Ready operand ignores a broadcast equal to its physical number
    dispatch(0, 20, 1, 5, 7);
    tick();
    disp_valid = 0;
    bc_valid = 1; bc_vpr = 5; bc_pr = 9;
    tick();
    bc_valid = 0;
    check("R4 no issue on ready-tag broadcast", int'(iss_valid), 0);
    bc_valid = 1; bc_vpr = 20; bc_pr = 2;
    tick();
    bc_valid = 0;
    check("R4 issue after real wake", int'(iss_valid), 1);
    check("R4 src0", int'(iss_src0_pr), 2);
    check("R4 src1 unchanged", int'(iss_src1_pr), 5);
    tick();

    // Both operands on one tag
    dispatch(0, 7, 0, 7, 3);
    tick();
    disp_valid = 0;
    bc_valid = 1; bc_vpr = 7; bc_pr = 11;
    tick();
    bc_valid = 0;
    check("R11 issue", int'(iss_valid), 1);
    check("R11 src0", int'(iss_src0_pr), 11);
    check("R11 src1", int'(iss_src1_pr), 11);
    tick();

    // Fill, stall, dropped dispatch, age order across slot reuse
    for (int k = 1; k <= 4; k++) begin
      dispatch(0, 10, 1, k, k);
      tick();
    end
    disp_valid = 0;
    check("R8 stall when full", int'(stall), 1);
    dispatch(1, 1, 1, 1, 9);
    tick();
    disp_valid = 0;
    check("R8 still full", int'(stall), 1);
    check("R8 no issue", int'(iss_valid), 0);
    bc_valid = 1; bc_vpr = 10; bc_pr = 6;
    tick();
    bc_valid = 0;
    check("R7 first issue valid", int'(iss_valid), 1);
    check("R7 oldest first", int'(iss_dst_vpr), 1);
    check("R7 woken src0", int'(iss_src0_pr), 6);
    tick();
    check("R7 second", int'(iss_dst_vpr), 2);
    check("R8 stall drops after issue", int'(stall), 0);
    dispatch(0, 10, 1, 0, 5);
    bc_valid = 1; bc_vpr = 10; bc_pr = 12;
    tick();
    disp_valid = 0; bc_valid = 0;
    check("R7 third", int'(iss_dst_vpr), 3);
    tick();
    check("R7 fourth", int'(iss_dst_vpr), 4);
    tick();
    check("R7 youngest last", int'(iss_dst_vpr), 5);
    check("R6 youngest src0", int'(iss_src0_pr), 12);
    tick();
    check("R8 dropped dispatch never issues", int'(iss_valid), 0);

    // Flush with dispatch in the same cycle
    dispatch(0, 30, 1, 1, 1);
    tick();
    dispatch(1, 2, 1, 3, 4);
    flush = 1;
    check("R9 no issue while flush", int'(iss_valid), 0);
    tick();
    flush = 0; disp_valid = 0;
    check("R9 flush drops dispatch", int'(iss_valid), 0);
    bc_valid = 1; bc_vpr = 30; bc_pr = 1;
    tick();
    bc_valid = 0;
    check("R9 flushed entry gone", int'(iss_valid), 0);
    check("R9 stall clear", int'(stall), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule